// File: doc/BRIEF.md
# Trigger-Synchronized Clock and Pulse Generator

The block runs on a fast oscillator clock and derives from it a divided output clock whose phase is restarted by an external trigger. Each restart also launches an active-low one-shot pulse that is aligned to the output clock and measured in whole output-clock periods. The trigger input is asynchronous. It passes through a two-flop synchronizer, and then an edge detector whose polarity the host selects.

A write-only host port holds the settings: trigger polarity, divide ratio and pulse length. The same port offers a software restart for systems that have no trigger source. Writing the command register with bit 0 set stops the output clock and holds it low. A following write with bit 0 clear restarts the clock on the edge where that write is taken. After reset the output clock stays stopped until the first restart.

Top module: `trig_sync_clkgen`

## Requirements
- R1: After reset `cko_o` is 0 and `pulse_no` is 1, and both hold until a restart occurs. The reset settings are falling-edge trigger, divide by 2 and pulse length 16.
- R2: A change on `trig_i` causes a restart at the third rising `clk_i` edge after it. Bit 0 of the mode register (address 2) selects the active edge: 0 selects falling and 1 selects rising. An edge of the other polarity has no effect.
- R3: At a restart edge `cko_o` goes to 1. From then on it toggles every H clock edges, where H = mode bits [3:1] + 1, so the divide ratio is 2H.
- R4: `pulse_no` goes low at the restart edge and stays low for exactly L `cko_o` periods, where L = bits [7:0] of the length register (address 1). When L = 0, no pulse is produced.
- R5: A write to address 3 with bit 0 = 1 arms the software restart. At the edge where that write is taken, `cko_o` is forced to 0 and held there, and any active pulse ends.
- R6: A write to address 3 with bit 0 = 0 while armed causes a restart at the edge where the write is taken, and clears the armed state.
- R7: A write to address 3 with bit 0 = 0 while not armed is ignored.
- R8: An active trigger edge that arrives during a pulse restarts both the divider and the full pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Asynchronous trigger |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Host register address |
| wr_data_i | input | 30 | Host write data |
| cko_o | output | 1 | Divided, trigger-synchronized clock |
| pulse_no | output | 1 | One-shot pulse, active low |

## Verification
The hardest case to reach is a trigger edge of the inactive polarity. While the output clock is running, such an edge leaves no visible mark. The stimulus therefore first stops the clock with the armed software command and then applies the inactive edge, so that any unwanted restart would show at once as clock activity. Retriggering in the middle of a pulse is reached by timing a second active edge a set number of cycles after the first. The checks then confirm that the full pulse length is counted again from the new restart.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LEN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd3;
endpackage

// File: rtl/tsg_trig_sync.sv
module tsg_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = rise_sel_i ? (s2_q & ~s3_q) : (~s2_q & s3_q);

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && $stable(rise_sel_i) |=> !edge_o); // R2
endmodule

// File: rtl/tsg_divider.sv
module tsg_divider #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] half_m1_i,
  output logic             cko_o,
  output logic             rise_o
);
  logic             run_q, cko_q;
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = run_q && (cnt_q >= half_m1_i);
  assign rise_o = wrap && !cko_q;
  assign cko_o  = cko_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cko_q <= 1'b0;
      cnt_q <= '0;
    end else if (halt_i) begin
      run_q <= 1'b0;
      cko_q <= 1'b0;
      cnt_q <= '0;
    end else if (restart_i) begin
      run_q <= 1'b1;
      cko_q <= 1'b1;
      cnt_q <= '0;
    end else if (wrap) begin
      cko_q <= ~cko_q;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HALT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !cko_o && !rise_o); // R5
  AST_RESTART_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i && !halt_i |=> cko_o); // R3
endmodule

// File: rtl/tsg_pulse.sv
module tsg_pulse #(
  parameter int PLEN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              restart_i,
  input  logic              rise_i,
  input  logic [PLEN_W-1:0] len_i,
  output logic              pulse_no
);
  logic              act_q;
  logic [PLEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (halt_i) begin
      act_q <= 1'b0;
    end else if (restart_i) begin
      act_q <= (len_i != '0);
      cnt_q <= len_i - 1'b1;
    end else if (act_q && rise_i) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_no = ~act_q;

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i && !halt_i && (len_i != '0) |=> !pulse_no); // R4
  AST_PULSE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i && (len_i == '0) |=> pulse_no); // R4
  AST_HALT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> pulse_no); // R5
endmodule

// File: rtl/trig_sync_clkgen.sv
module trig_sync_clkgen
  import tsg_pkg::*;
#(
  parameter int DATA_W = 30,
  parameter int DIV_W  = 3,
  parameter int PLEN_W = 8,
  parameter int PLEN_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              cko_o,
  output logic              pulse_no
);
  localparam int USED_W = (PLEN_W > DIV_W + 1) ? PLEN_W : DIV_W + 1;

  logic              rise_sel_q, armed_q;
  logic [DIV_W-1:0]  half_m1_q;
  logic [PLEN_W-1:0] len_q;
  logic              cmd_wr, arm_wr, fire_wr, trig_edge, restart, cko_rise;
  logic              unused_data;

  assign unused_data = ^wr_data_i[DATA_W-1:USED_W];

  assign cmd_wr  = wr_en_i && (wr_addr_i == A_CMD);
  assign arm_wr  = cmd_wr && wr_data_i[0];
  assign fire_wr = cmd_wr && !wr_data_i[0] && armed_q;
  assign restart = fire_wr || (trig_edge && !arm_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_sel_q <= 1'b0;
      half_m1_q  <= '0;
      len_q      <= PLEN_W'(PLEN_RST);
      armed_q    <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_MODE) begin
        rise_sel_q <= wr_data_i[0];
        half_m1_q  <= wr_data_i[DIV_W:1];
      end
      if (wr_en_i && wr_addr_i == A_LEN) len_q <= wr_data_i[PLEN_W-1:0];
      if (arm_wr)       armed_q <= 1'b1;
      else if (restart) armed_q <= 1'b0;
    end
  end

  tsg_trig_sync u_sync (
    .clk_i, .rst_ni, .trig_i,
    .rise_sel_i (rise_sel_q),
    .edge_o     (trig_edge)
  );

  tsg_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .halt_i    (arm_wr),
    .restart_i (restart),
    .half_m1_i (half_m1_q),
    .cko_o     (cko_o),
    .rise_o    (cko_rise)
  );

  tsg_pulse #(.PLEN_W(PLEN_W)) u_pulse (
    .clk_i, .rst_ni,
    .halt_i    (arm_wr),
    .restart_i (restart),
    .rise_i    (cko_rise),
    .len_i     (len_q),
    .pulse_no  (pulse_no)
  );

  AST_FIRE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_wr |=> !armed_q); // R6
  AST_UNARMED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !wr_data_i[0] && !armed_q && !trig_edge |=> $stable(cko_o) || $past(cko_rise) || $past(cko_o)); // R7
  AST_ARM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !restart && !arm_wr |=> !cko_o); // R5
endmodule

// File: tb/trig_sync_clkgen_tb_top.sv
module trig_sync_clkgen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [29:0] wr_data = '0;
  logic        cko, pulse_n;
  int          errors = 0, checks = 0;

  always #10 clk = ~clk;

  trig_sync_clkgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cko_o(cko), .pulse_no(pulse_n)
  );

  function automatic logic exp_cko(int i, int h);
    return ((i / h) % 2) == 0;
  endfunction

  function automatic logic exp_pn(int i, int h, int l);
    return !(i < 2 * h * l);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [29:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called at the negedge just after the restart edge
  task automatic observe(int h, int l, string req);
    int bad = 0;
    for (int i = 0; i < 2 * h * l + 4 * h; i++) begin
      if (cko !== exp_cko(i, h) || pulse_n !== exp_pn(i, h, l)) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic hold_stopped(int n, string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (cko !== 1'b0 || pulse_n !== 1'b1) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic toggle_trig();
    trig = ~trig;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cko === 1'b0 && pulse_n === 1'b1, "R1 reset outputs", {cko, pulse_n}, 1);
    hold_stopped(12, "R1 halted after reset");

    wr(2'd3, 30'd0);
    hold_stopped(20, "R7 unarmed fire ignored");

    toggle_trig();  // 1->0 falling, defaults H=1 L=16
    observe(1, 16, "R1 R2 R3 R4 default restart");

    repeat (5) @(negedge clk);
    wr(2'd3, 30'd1);
    hold_stopped(20, "R5 armed halt");
    wr(2'd3, 30'd0);
    observe(1, 16, "R6 software restart");

    wr(2'd2, 30'h1);  // rising, H=1
    trig = 1'b1;       // rising: restart, overridden below
    repeat (6) @(negedge clk);
    wr(2'd3, 30'd1);
    trig = 1'b0;       // falling: inactive
    repeat (3) @(negedge clk);
    hold_stopped(20, "R2 inactive edge ignored");
    toggle_trig();     // 0->1 rising
    observe(1, 16, "R2 rising edge restart");

    wr(2'd1, 30'd0);
    wr(2'd2, 30'd2);  // falling, H=2
    repeat (6) @(negedge clk);
    toggle_trig();     // 1->0
    observe(2, 0, "R4 zero length no pulse");

    wr(2'd1, 30'd10);
    trig = 1'b1;
    repeat (6) @(negedge clk);
    toggle_trig();
    repeat (15) @(negedge clk);
    check(pulse_n === 1'b0, "R4 pulse mid active", pulse_n, 0);
    trig = 1'b1;
    repeat (4) @(negedge clk);
    toggle_trig();
    observe(2, 10, "R8 retrigger restarts pulse");

    for (int k = 0; k < 10; k++) begin
      int hm, l, rs;
      hm = $urandom % 4; l = 1 + $urandom % 6; rs = $urandom % 2;
      wr(2'd1, 30'(l));
      wr(2'd2, 30'((hm << 1) | rs));
      trig = (rs == 1) ? 1'b0 : 1'b1;
      repeat (6) @(negedge clk);
      toggle_trig();
      observe(hm + 1, l, "R2 R3 R4 random config");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule